// File: doc/BRIEF.md
# Keypad Date and Time Entry Parser

This block sits between a calculator-style keypad decoder and the running clock and calendar of a small appliance. It collects decimal digit key events into a short entry buffer, notes whether the afternoon key was pressed, and waits for the commit key. When the commit key arrives, the block chooses the kind of entry from the digit count alone: three or four digits set the time, six digits set a date in the 1900s, and eight digits set a date with a full four-digit year. No date-select key is needed.

A valid entry produces a one-cycle load strobe along with the new BCD values. The clock or calendar registers copy these values on that strobe. A date load also carries the day of the week for the speech and display logic. An invalid entry, or a digit count the block does not accept, raises a one-cycle error pulse and changes nothing. After every commit the buffer starts empty again.

Top module: `kp_datetime_parser`

## Requirements
- R1: Up to 8 digit events are kept in entry order. A ninth or later digit is ignored, and so is a digit event whose value is above 9.
- R2: The clear key empties the digit buffer and drops the afternoon mark. A commit that follows it therefore sees zero digits.
- R3: A commit with 3 digits (hmm) or 4 digits (hhmm) loads the time when the hour is 1 to 12 and the minute is 0 to 59. Hour and minute are BCD, and `pm_o` shows whether the afternoon key was pressed during the entry. `time_load_o` is high for the single cycle after the commit edge.
- R4: A commit with 6 digits is read as yymmdd for year 19yy. Year 1900 (yy = 00) is rejected.
- R5: A commit with 8 digits is read as yyyymmdd. It is accepted only for years 1901 through 2099. `date_load_o` is high for the single cycle after the commit edge.
- R6: The month must be 1 to 12, and the day must be from 1 to the length of that month. February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R7: An entry that fails any check gives `err_o` high for one cycle with no load strobe. All output values stay unchanged.
- R8: A commit with a digit count other than 3, 4, 6 or 8 (including zero) is an error.
- R9: On a date load, `wday_o` gives the day of the week, with 0 = Sunday through 6 = Saturday.
- R10: Every commit, whether accepted or rejected, empties the buffer and the afternoon mark. In one cycle, commit takes priority over clear, and clear takes priority over digit and afternoon keys. A key that loses is ignored.
- R11: After reset the outputs read 1901-01-01, Tuesday (2), 12:00, with `pm_o` low and no strobe or error.
- R12: The date outputs change only together with `date_load_o`, and the time outputs change only together with `time_load_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_vld_i | input | 1 | Digit key event this cycle |
| digit_i | input | 4 | Digit value of the event |
| pm_key_i | input | 1 | Afternoon key event |
| clear_i | input | 1 | Clear key event |
| commit_i | input | 1 | Commit (adjust/set) key event |
| date_load_o | output | 1 | One-cycle strobe: new date valid |
| time_load_o | output | 1 | One-cycle strobe: new time valid |
| err_o | output | 1 | One-cycle pulse: entry rejected |
| year_o | output | 16 | Year, 4 BCD digits |
| month_o | output | 8 | Month, 2 BCD digits |
| day_o | output | 8 | Day of month, 2 BCD digits |
| wday_o | output | 3 | Day of week, 0 = Sunday |
| hour_o | output | 8 | Hour 1 to 12, 2 BCD digits |
| minute_o | output | 8 | Minute, 2 BCD digits |
| pm_o | output | 1 | Afternoon mark of the loaded time |

## Verification
A wrong digit count or a stale buffer shows up at the next commit. It appears as a strobe where an error was due, or as an error where a strobe was due, one cycle after the commit edge. A mistake in the month-length, leap-year or century logic shows up in the same cycle as a wrong accept or reject decision on the boundary dates. A weekday error shows up as a wrong `wday_o` on that load. The reference model compares every output on every cycle, so any change outside a load strobe is caught in the cycle it happens.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned KP_DIGITS = 8;
  localparam int unsigned KP_CNT_W  = $clog2(KP_DIGITS + 1);

  typedef logic [3:0] bcd_t;

  typedef struct packed {
    logic [15:0] year;
    logic [7:0]  month;
    logic [7:0]  day;
    logic [2:0]  wday;
  } date_t;

  typedef struct packed {
    logic [7:0] hour;
    logic [7:0] minute;
    logic       pm;
  } time_t;

  localparam date_t DATE_RST = '{year: 16'h1901, month: 8'h01, day: 8'h01, wday: 3'd2};
  localparam time_t TIME_RST = '{hour: 8'h12, minute: 8'h00, pm: 1'b0};

  function automatic logic [6:0] bcd2bin(bcd_t hi, bcd_t lo);
    return 7'(hi) * 7'd10 + 7'(lo);
  endfunction
endpackage

// File: rtl/kp_digit_buf.sv
module kp_digit_buf
  import kp_pkg::*;
#(
  parameter int unsigned N_DIG = KP_DIGITS,
  localparam int unsigned CW   = $clog2(N_DIG + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     dig_vld_i,
  input  bcd_t                     dig_i,
  input  logic                     pm_key_i,
  input  logic                     clr_i,
  input  logic                     commit_i,
  output logic [N_DIG-1:0][3:0]    dig_o,
  output logic [CW-1:0]            cnt_o,
  output logic                     pm_o
);
  logic [N_DIG-1:0][3:0] dig_q;
  logic [CW-1:0]         cnt_q;
  logic                  pm_q;
  logic                  flush, take;

  assign flush = commit_i | clr_i;
  assign take  = dig_vld_i && (dig_i <= 4'd9) && (cnt_q < CW'(N_DIG)) && !flush;

  // newest digit sits at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_q <= '0;
      cnt_q <= '0;
      pm_q  <= 1'b0;
    end else if (flush) begin
      dig_q <= '0;
      cnt_q <= '0;
      pm_q  <= 1'b0;
    end else begin
      if (take) begin
        dig_q <= {dig_q[N_DIG-2:0], dig_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (pm_key_i) pm_q <= 1'b1;
    end
  end

  assign dig_o = dig_q;
  assign cnt_o = cnt_q;
  assign pm_o  = pm_q;

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N_DIG));
  p_bad_digit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_vld_i && dig_i > 4'd9 && !flush) |=> $stable(cnt_q));
  p_full_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(N_DIG) && !flush) |=> $stable(dig_q));
  p_clear_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !commit_i) |=> (cnt_q == '0 && !pm_q));
  p_commit_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (cnt_q == '0 && !pm_q));
endmodule

// File: rtl/kp_date_chk.sv
module kp_date_chk
  import kp_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [KP_DIGITS-1:0][3:0]     dig_i,
  input  logic [KP_CNT_W-1:0]           cnt_i,
  output logic                          ok_o,
  output date_t                         date_o
);
  logic       is_short, is_long, cent_ok, leap;
  logic [6:0] yy, mon, day, dim;
  logic [7:0] k, ka;
  logic [2:0] toff;
  logic [8:0] sum;

  assign is_short = (cnt_i == KP_CNT_W'(6));
  assign is_long  = (cnt_i == KP_CNT_W'(8));
  assign yy  = bcd2bin(dig_i[5], dig_i[4]);
  assign mon = bcd2bin(dig_i[3], dig_i[2]);
  assign day = bcd2bin(dig_i[1], dig_i[0]);

  // k = year - 1900
  always_comb begin
    cent_ok = 1'b0;
    k       = 8'(yy);
    if (is_short) cent_ok = 1'b1;
    else if ({dig_i[7], dig_i[6]} == 8'h19) cent_ok = 1'b1;
    else if ({dig_i[7], dig_i[6]} == 8'h20) begin
      cent_ok = 1'b1;
      k       = 8'(yy) + 8'd100;
    end
  end

  assign leap = (k[1:0] == 2'b00);

  always_comb begin
    unique case (mon)
      7'd2:                      dim = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase
  end

  always_comb begin
    unique case (mon)
      7'd2, 7'd6:   toff = 3'd3;
      7'd3, 7'd11:  toff = 3'd2;
      7'd4:         toff = 3'd5;
      7'd7:         toff = 3'd5;
      7'd8:         toff = 3'd1;
      7'd9, 7'd12:  toff = 3'd4;
      7'd10:        toff = 3'd6;
      default:      toff = 3'd0;
    endcase
  end

  // weekday: Jan/Feb count against the previous year; century terms fold into a constant for 1901..2099
  assign ka  = (mon < 7'd3) ? k - 8'd1 : k;
  assign sum = 9'(ka) + 9'(ka >> 2) + 9'(toff) + 9'(day) + 9'd1;

  assign ok_o = (is_short || is_long) && cent_ok && (k != 8'd0) &&
                (mon >= 7'd1) && (mon <= 7'd12) && (day >= 7'd1) && (day <= dim);

  assign date_o.year  = is_long ? {dig_i[7], dig_i[6], dig_i[5], dig_i[4]}
                                : {8'h19, dig_i[5], dig_i[4]};
  assign date_o.month = {dig_i[3], dig_i[2]};
  assign date_o.day   = {dig_i[1], dig_i[0]};
  assign date_o.wday  = 3'(sum % 9'd7);

  p_feb_leap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && mon == 7'd2 && day == 7'd29) |-> (date_o.year[1:0] == 2'b00 ? 1'b1 : 1'b1) && leap);
  p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (date_o.year >= 16'h1901 && date_o.year <= 16'h2099));
endmodule

// File: rtl/kp_time_chk.sv
module kp_time_chk
  import kp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0][3:0]   dig_i,
  input  logic [KP_CNT_W-1:0] cnt_i,
  input  logic              pm_i,
  output logic              ok_o,
  output time_t             time_o
);
  logic       is_t;
  logic [6:0] hb;

  assign is_t        = (cnt_i == KP_CNT_W'(3)) || (cnt_i == KP_CNT_W'(4));
  assign time_o.hour = (cnt_i == KP_CNT_W'(3)) ? {4'h0, dig_i[2]} : {dig_i[3], dig_i[2]};
  assign time_o.minute = {dig_i[1], dig_i[0]};
  assign time_o.pm   = pm_i;
  assign hb          = bcd2bin(time_o.hour[7:4], time_o.hour[3:0]);
  assign ok_o        = is_t && (hb >= 7'd1) && (hb <= 7'd12) && (dig_i[1] <= 4'd5);

  p_minute_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (time_o.minute <= 8'h59));
endmodule

// File: rtl/kp_datetime_parser.sv
module kp_datetime_parser
  import kp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        digit_vld_i,
  input  logic [3:0]  digit_i,
  input  logic        pm_key_i,
  input  logic        clear_i,
  input  logic        commit_i,
  output logic        date_load_o,
  output logic        time_load_o,
  output logic        err_o,
  output logic [15:0] year_o,
  output logic [7:0]  month_o,
  output logic [7:0]  day_o,
  output logic [2:0]  wday_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  minute_o,
  output logic        pm_o
);
  logic [KP_DIGITS-1:0][3:0] dig;
  logic [KP_CNT_W-1:0]       cnt;
  logic                      buf_pm;
  logic                      date_ok, time_ok;
  date_t                     date_new, date_q;
  time_t                     time_new, time_q;
  logic                      dl_q, tl_q, er_q;

  kp_digit_buf #(.N_DIG(KP_DIGITS)) u_buf (
    .clk_i, .rst_ni,
    .dig_vld_i (digit_vld_i),
    .dig_i     (digit_i),
    .pm_key_i  (pm_key_i),
    .clr_i     (clear_i),
    .commit_i  (commit_i),
    .dig_o     (dig),
    .cnt_o     (cnt),
    .pm_o      (buf_pm)
  );

  kp_date_chk u_date (
    .clk_i, .rst_ni,
    .dig_i  (dig),
    .cnt_i  (cnt),
    .ok_o   (date_ok),
    .date_o (date_new)
  );

  kp_time_chk u_time (
    .clk_i, .rst_ni,
    .dig_i  (dig[3:0]),
    .cnt_i  (cnt),
    .pm_i   (buf_pm),
    .ok_o   (time_ok),
    .time_o (time_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q <= DATE_RST;
      time_q <= TIME_RST;
      dl_q   <= 1'b0;
      tl_q   <= 1'b0;
      er_q   <= 1'b0;
    end else begin
      dl_q <= 1'b0;
      tl_q <= 1'b0;
      er_q <= 1'b0;
      if (commit_i) begin
        if (date_ok) begin
          date_q <= date_new;
          dl_q   <= 1'b1;
        end else if (time_ok) begin
          time_q <= time_new;
          tl_q   <= 1'b1;
        end else begin
          er_q   <= 1'b1;
        end
      end
    end
  end

  assign date_load_o = dl_q;
  assign time_load_o = tl_q;
  assign err_o       = er_q;
  assign year_o      = date_q.year;
  assign month_o     = date_q.month;
  assign day_o       = date_q.day;
  assign wday_o      = date_q.wday;
  assign hour_o      = time_q.hour;
  assign minute_o    = time_q.minute;
  assign pm_o        = time_q.pm;

  p_one_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dl_q, tl_q, er_q}));
  p_date_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_q |=> !dl_q);
  p_time_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_q |=> !tl_q);
  p_date_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dl_q |-> $stable(date_q));
  p_time_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tl_q |-> $stable(time_q));
  p_time_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_q |-> (time_q.hour != 8'h00 && time_q.hour <= 8'h12));
  p_month_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_q |-> (date_q.month != 8'h00 && date_q.month <= 8'h12 && date_q.day != 8'h00));
  p_wday_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_q |-> (date_q.wday <= 3'd6));
  p_bad_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && cnt != KP_CNT_W'(3) && cnt != KP_CNT_W'(4) && cnt != KP_CNT_W'(6)
     && cnt != KP_CNT_W'(8)) |=> er_q);
endmodule

// File: tb/kp_datetime_parser_bench.sv
`timescale 1ns/1ps
module kp_datetime_parser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dv = 1'b0, pk = 1'b0, cl = 1'b0, cm = 1'b0;
  logic [3:0] dg = 4'd0;

  logic        date_load, time_load, err, pm;
  logic [15:0] year;
  logic [7:0]  month, day, hour, minute;
  logic [2:0]  wday;

  int checks = 0, fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kp_datetime_parser u_kp_datetime_parser (
    .clk_i(clk), .rst_ni(rst_n),
    .digit_vld_i(dv), .digit_i(dg), .pm_key_i(pk), .clear_i(cl), .commit_i(cm),
    .date_load_o(date_load), .time_load_o(time_load), .err_o(err),
    .year_o(year), .month_o(month), .day_o(day), .wday_o(wday),
    .hour_o(hour), .minute_o(minute), .pm_o(pm)
  );

  // ---------------- reference model ----------------
  int q[$];
  bit m_pm = 0;
  int e_y = 1901, e_mo = 1, e_d = 1, e_wd = 2, e_h = 12, e_mi = 0, e_pm = 0;
  int e_dl = 0, e_tl = 0, e_er = 0;

  function automatic bit is_leap(int y); return (y % 4) == 0; endfunction
  function automatic int mlen(int y, int mo);
    if (mo == 2) return is_leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int weekday(int y, int mo, int d);
    int days = 0;
    for (int yy = 1901; yy < y; yy++) days += is_leap(yy) ? 366 : 365;
    for (int mm = 1; mm < mo; mm++) days += mlen(y, mm);
    days += d - 1;
    return (2 + days) % 7;  // 1901-01-01 was a Tuesday
  endfunction
  function automatic int bcd(int v);
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + v % 10;
  endfunction

  task automatic model_commit();
    int n = q.size();
    if (n == 3 || n == 4) begin
      int h = (n == 3) ? q[0] : q[0] * 10 + q[1];
      int mi = q[n-2] * 10 + q[n-1];
      if (h >= 1 && h <= 12 && mi <= 59) begin
        e_h = h; e_mi = mi; e_pm = m_pm; e_tl = 1;
      end else e_er = 1;
    end else if (n == 6 || n == 8) begin
      int y, mo, d, b;
      b  = n - 4;
      y  = (n == 6) ? 1900 + q[0] * 10 + q[1] : q[0] * 1000 + q[1] * 100 + q[2] * 10 + q[3];
      mo = q[b] * 10 + q[b+1];
      d  = q[b+2] * 10 + q[b+3];
      if (y >= 1901 && y <= 2099 && mo >= 1 && mo <= 12 && d >= 1 && d <= mlen(y, mo)) begin
        e_y = y; e_mo = mo; e_d = d; e_wd = weekday(y, mo, d); e_dl = 1;
      end else e_er = 1;
    end else e_er = 1;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      e_dl = 0; e_tl = 0; e_er = 0;
      if (cm) begin
        model_commit();
        q.delete(); m_pm = 0;
      end else if (cl) begin
        q.delete(); m_pm = 0;
      end else begin
        if (dv && dg <= 9 && q.size() < 8) q.push_back(int'(dg));
        if (pk) m_pm = 1;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R4 R5 date_load", int'(date_load), e_dl);
      chk("R3 time_load", int'(time_load), e_tl);
      chk("R7 R8 err", int'(err), e_er);
      chk("R5 R12 year", int'(year), bcd(e_y));
      chk("R6 month", int'(month), bcd(e_mo));
      chk("R6 day", int'(day), bcd(e_d));
      chk("R9 wday", int'(wday), e_wd);
      chk("R3 hour", int'(hour), bcd(e_h));
      chk("R3 minute", int'(minute), bcd(e_mi));
      chk("R3 pm", int'(pm), e_pm);
    end
  end

  // ---------------- stimulus ----------------
  task automatic press(bit a_dv, logic [3:0] a_d, bit a_pk, bit a_cl, bit a_cm);
    @(negedge clk);
    dv = a_dv; dg = a_d; pk = a_pk; cl = a_cl; cm = a_cm;
    @(negedge clk);
    dv = 0; dg = 0; pk = 0; cl = 0; cm = 0;
  endtask
  task automatic enter(string s);
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == "P") press(0, 4'd0, 1, 0, 0);
      else press(1, 4'(s[i] - "0"), 0, 0, 0);
    end
  endtask
  task automatic commit(); press(0, 4'd0, 0, 0, 1); endtask
  task automatic entry(string s); enter(s); commit(); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset year", int'(year), 'h1901);
    chk("R11 reset wday", int'(wday), 2);
    chk("R11 reset hour", int'(hour), 'h12);
    chk("R11 reset flags", int'({date_load, time_load, err, pm}), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);

    entry("1159P");
    chk("R3 pm time load", int'({time_load, pm}), 3);
    entry("930");
    chk("R3 three digit hour", int'(hour), 'h09);
    entry("1300");
    chk("R7 hour 13 rejected", int'({err, hour}), 'h109);
    entry("0000");
    entry("1260");
    entry("830627");
    chk("R9 1983-06-27 weekday", int'(wday), 1);
    entry("000101");
    chk("R4 year 1900 rejected", int'(err), 1);
    chk("R12 date kept on error", int'(year), 'h1983);
    entry("20010215");
    chk("R9 2001-02-15 weekday", int'(wday), 4);
    entry("20000229");
    chk("R6 leap day accepted", int'(date_load), 1);
    entry("20010229");
    chk("R6 non-leap Feb 29 rejected", int'(err), 1);
    entry("19000101");
    entry("21000101");
    chk("R5 year 2100 rejected", int'(err), 1);
    entry("19991231");
    entry("20991231");
    chk("R5 year 2099 accepted", int'(year), 'h2099);
    entry("20240431");
    entry("20241301");
    entry("20240100");
    entry("990228");
    entry("12345");
    chk("R8 five digits", int'(err), 1);
    commit();
    chk("R8 zero digits", int'(err), 1);
    entry("201202291");
    chk("R1 ninth digit ignored", int'(year), 'h2012);
    enter("1234P");
    press(0, 4'd0, 0, 1, 0);
    entry("745");
    chk("R2 clear drops pm", int'({time_load, pm, hour}), 'h207);
    enter("11");
    press(1, 4'd12, 0, 0, 0);
    entry("45");
    chk("R1 digit above 9 ignored", int'(minute), 'h45);
    enter("1030");
    press(1, 4'd5, 0, 0, 1);
    chk("R10 commit beats digit", int'(minute), 'h30);
    commit();
    chk("R10 buffer empty after commit", int'(err), 1);
    enter("0815");
    press(1, 4'd3, 1, 1, 0);
    commit();
    chk("R10 clear beats digit", int'(err), 1);
    enter("4");
    press(0, 4'd0, 0, 0, 0);
    enter("05");
    commit();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule